// File: doc/BRIEF.md
# Per-Channel Loopback and Gating Datapath for a 2B+D Interface

This block sits between a line transceiver core and a time-slotted digital port. It carries two bearer channels (B1, B2) and one signalling channel (D). A framing stub raises one slot strobe per channel while that channel's bits are present. During each strobed cycle the block decides what goes toward the line and what goes toward the digital port. The choice depends on two configuration bytes, the termination polarity input and an external bearer transparency permit.

Each channel can be looped back on the line side, on the digital side, or on both. While a loop is active, the direction that is not looped either passes data through or is forced to a fill value. Each channel can also be disabled. A disabled channel releases the digital output driver, ignores the digital input, and sends the idle fill value toward the line. The idle fill is ones for network termination and zeros for line termination.

All data outputs are registered, one cycle after the inputs. Configuration is written through a small address/data/strobe port and read back on a registered read port.

Top module: `slot_loop_router`

## Requirements
- R1: While reset is held, `line_tx` is 0, `dig_tx` is all ones and `dig_tx_oe` is 0. After reset, the loop byte (address 0) reads 0x00 and the enable byte (address 1) reads 0xE0.
- R2: A write stores all 8 bits at the addressed byte. `cfg_rdata` returns the byte at `cfg_addr` one cycle after the address is presented.
- R3: Outside any slot strobe, or in an enabled and permitted slot with no loopback, `line_tx` takes `dig_rx`, `dig_tx` takes `line_rx`, and `dig_tx_oe` is 1.
- R4: Loop byte bits 7, 6 and 5 are the line-side loops for B1, B2 and D. When a channel's line loop is set, `line_tx` carries `line_rx` in that channel's slot.
- R5: Loop byte bits 4, 3 and 2 are the digital-side loops for B1, B2 and D. When a channel's digital loop is set, `dig_tx` carries `dig_rx` in that channel's slot.
- R6: When loop byte bit 1 (transparent) is 0 and only the line loop is set for a channel, `dig_tx` is all ones in that slot.
- R7: When the transparent bit is 0 and only the digital loop is set for a channel, `line_tx` in that slot equals `nt_mode`: 1 for network termination, 0 for line termination.
- R8: When the transparent bit is 1, the direction that is not looped passes through unchanged: `line_tx` = `dig_rx` or `dig_tx` = `line_rx`.
- R9: Enable byte bits 7, 6 and 5 enable B1, B2 and D. In a disabled channel's slot, `dig_tx_oe` is 0, `dig_tx` is all ones, `dig_rx` has no effect, and `line_tx` equals `nt_mode`.
- R10: In an enabled bearer slot with `xpar_ok` low, `line_tx` equals `nt_mode`, `dig_tx` is all ones and `dig_tx_oe` is 1. The D channel does not depend on `xpar_ok`.
- R11: Outputs change only at a clock edge. A new input value appears at the outputs after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Byte select: 0 loop byte, 1 enable byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| nt_mode | input | 1 | 1 network termination, 0 line termination |
| xpar_ok | input | 1 | Bearer transparency permit |
| slot_sel | input | 3 | Slot strobes, bit 0 B1, bit 1 B2, bit 2 D; at most one high |
| line_rx | input | 1 | Bit received from the line |
| dig_rx | input | 1 | Bit received from the digital port |
| line_tx | output | 1 | Bit sent to the line |
| dig_tx | output | 1 | Bit sent to the digital port |
| dig_tx_oe | output | 1 | Drive enable for `dig_tx` |

## Verification
The bench sweeps every combination of the seven loop bits, the three enables, both polarities, the permit, every slot (including no slot) and both data values on each side. This covers the cases where both loops of one channel are active together. A design that forced a fill value on a direction that is already looped would send fill instead of the looped bit. The sweep also separates bearer channels from the D channel under a low permit, and it catches a bit-order swap between channel index and register bit. A disabled slot is checked with `dig_rx` at both values, so a design that let the digital input leak through would be seen on `line_tx`. A combinational datapath would fail the check taken between edges.

// File: rtl/slr_pkg.sv
`timescale 1ns/1ps
package slr_pkg;
  localparam int NUM_CH     = 3;
  localparam int NUM_BEARER = 2;
  localparam int CFG_W      = 8;
  localparam int CFG_ADDR_W = 1;
  localparam logic [CFG_W-1:0] LOOP_RST = 8'h00;
  localparam logic [CFG_W-1:0] EN_RST   = 8'hE0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_LOOP = 1'b0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_EN   = 1'b1;
endpackage

// File: rtl/slr_cfg_regs.sv
`timescale 1ns/1ps
module slr_cfg_regs
  import slr_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] loop_q,
  output logic [DATA_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loop_q <= DATA_W'(LOOP_RST);
      en_q   <= DATA_W'(EN_RST);
      rdata  <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(ADDR_LOOP)) loop_q <= wdata;
      if (wr_en && addr == ADDR_W'(ADDR_EN))   en_q   <= wdata;
      if (addr == ADDR_W'(ADDR_EN))        rdata <= en_q;
      else if (addr == ADDR_W'(ADDR_LOOP)) rdata <= loop_q;
      else                                 rdata <= '0;
    end
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(ADDR_EN)) |=> (en_q == $past(wdata))); // R2
  AST_LOOP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(ADDR_LOOP)) |=> (loop_q == $past(wdata))); // R2
endmodule

// File: rtl/slr_chan_path.sv
`timescale 1ns/1ps
module slr_chan_path #(
  parameter int LANE_W    = 1,
  parameter bit IS_BEARER = 1'b1
) (
  input  logic              en,
  input  logic              permit,
  input  logic              line_lb,
  input  logic              dig_lb,
  input  logic              xparent,
  input  logic              nt_mode,
  input  logic [LANE_W-1:0] line_rx,
  input  logic [LANE_W-1:0] dig_rx,
  output logic [LANE_W-1:0] line_tx,
  output logic [LANE_W-1:0] dig_tx,
  output logic              dig_oe
);
  logic [LANE_W-1:0] fill_line;
  logic              allowed;

  assign fill_line = {LANE_W{nt_mode}};
  assign allowed   = IS_BEARER ? permit : 1'b1;

  always_comb begin
    dig_oe  = 1'b1;
    dig_tx  = '1;
    line_tx = fill_line;
    if (!en) begin
      dig_oe = 1'b0;
    end else if (allowed) begin
      if (line_lb)                  line_tx = line_rx;
      else if (dig_lb && !xparent)  line_tx = fill_line;
      else                          line_tx = dig_rx;
      if (dig_lb)                   dig_tx = dig_rx;
      else if (line_lb && !xparent) dig_tx = '1;
      else                          dig_tx = line_rx;
    end
  end
endmodule

// File: rtl/slot_loop_router.sv
`timescale 1ns/1ps
module slot_loop_router
  import slr_pkg::*;
#(
  parameter int LANE_W  = 1,
  parameter int N_CH    = NUM_CH,
  parameter int N_BEAR  = NUM_BEARER,
  parameter int CW      = CFG_W,
  parameter int AW      = CFG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic [CW-1:0]     cfg_rdata,
  input  logic              nt_mode,
  input  logic              xpar_ok,
  input  logic [N_CH-1:0]   slot_sel,
  input  logic [LANE_W-1:0] line_rx,
  input  logic [LANE_W-1:0] dig_rx,
  output logic [LANE_W-1:0] line_tx,
  output logic [LANE_W-1:0] dig_tx,
  output logic              dig_tx_oe
);
  localparam int LLB_TOP = CW - 1;
  localparam int DLB_TOP = CW - 1 - N_CH;
  localparam int XP_BIT  = CW - 1 - 2 * N_CH;
  localparam int EN_TOP  = CW - 1;

  logic [CW-1:0]     loop_q, en_q;
  logic [N_CH-1:0]   line_lb, dig_lb, ch_en, ch_oe, ch_pass;
  logic [LANE_W-1:0] ch_ltx [N_CH];
  logic [LANE_W-1:0] ch_dtx [N_CH];
  logic              xparent;
  logic [LANE_W-1:0] nxt_ltx, nxt_dtx;
  logic              nxt_oe;
  logic              unused_cfg;

  slr_cfg_regs #(.ADDR_W(AW), .DATA_W(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .loop_q(loop_q), .en_q(en_q)
  );

  assign xparent    = loop_q[XP_BIT];
  assign unused_cfg = ^{loop_q[XP_BIT-1:0], en_q[EN_TOP-N_CH:0]};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign line_lb[c] = loop_q[LLB_TOP - c];
    assign dig_lb[c]  = loop_q[DLB_TOP - c];
    assign ch_en[c]   = en_q[EN_TOP - c];
    assign ch_pass[c] = ch_en[c] && ((c >= N_BEAR) || xpar_ok);

    slr_chan_path #(.LANE_W(LANE_W), .IS_BEARER(c < N_BEAR)) u_path (
      .en(ch_en[c]), .permit(xpar_ok), .line_lb(line_lb[c]),
      .dig_lb(dig_lb[c]), .xparent(xparent), .nt_mode(nt_mode),
      .line_rx(line_rx), .dig_rx(dig_rx),
      .line_tx(ch_ltx[c]), .dig_tx(ch_dtx[c]), .dig_oe(ch_oe[c])
    );

    AST_LINE_LOOP: assert property (@(posedge clk) disable iff (rst)
      ($onehot0(slot_sel) && slot_sel[c] && ch_pass[c] && line_lb[c])
      |=> (line_tx == $past(line_rx))); // R4
    AST_DIG_LOOP: assert property (@(posedge clk) disable iff (rst)
      ($onehot0(slot_sel) && slot_sel[c] && ch_pass[c] && dig_lb[c])
      |=> (dig_tx == $past(dig_rx))); // R5
    AST_FORCE_DIG_ONES: assert property (@(posedge clk) disable iff (rst)
      ($onehot0(slot_sel) && slot_sel[c] && ch_pass[c] && line_lb[c] && !dig_lb[c] && !xparent)
      |=> (dig_tx == '1)); // R6
    AST_OFF_HIZ: assert property (@(posedge clk) disable iff (rst)
      ($onehot0(slot_sel) && slot_sel[c] && !ch_en[c])
      |=> (!dig_tx_oe && line_tx == {LANE_W{$past(nt_mode)}})); // R9
  end

  always_comb begin
    nxt_ltx = dig_rx;
    nxt_dtx = line_rx;
    nxt_oe  = 1'b1;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (slot_sel[c]) begin
        nxt_ltx = ch_ltx[c];
        nxt_dtx = ch_dtx[c];
        nxt_oe  = ch_oe[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_tx   <= '0;
      dig_tx    <= '1;
      dig_tx_oe <= 1'b0;
    end else begin
      line_tx   <= nxt_ltx;
      dig_tx    <= nxt_dtx;
      dig_tx_oe <= nxt_oe;
    end
  end

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_sel)); // R3
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (slot_sel == '0) |=> (dig_tx_oe && line_tx == $past(dig_rx) && dig_tx == $past(line_rx))); // R3
endmodule

// File: tb/slot_loop_router_tb.sv
`timescale 1ns/1ps
module slot_loop_router_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [0:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       nt_mode = 1'b0, xpar_ok = 1'b0;
  logic [2:0] slot_sel = '0;
  logic [0:0] line_rx = '0, dig_rx = '0;
  logic [0:0] line_tx, dig_tx;
  logic       dig_tx_oe;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  slot_loop_router u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .nt_mode(nt_mode),
    .xpar_ok(xpar_ok), .slot_sel(slot_sel), .line_rx(line_rx),
    .dig_rx(dig_rx), .line_tx(line_tx), .dig_tx(dig_tx), .dig_tx_oe(dig_tx_oe)
  );

  // expected {oe, dig_tx, line_tx}; sel 3 means no slot
  function automatic logic [2:0] model(input logic [7:0] lb, input logic [7:0] en,
      input logic nt, input logic pm, input int sel, input logic lr, input logic dr);
    logic ll, dl, xp, ltx, dtx;
    if (sel == 3) return {1'b1, lr, dr};
    ll = lb[7-sel]; dl = lb[4-sel]; xp = lb[1];
    if (!en[7-sel]) return {1'b0, 1'b1, nt};
    if (sel < 2 && !pm) return {1'b1, 1'b1, nt};
    ltx = ll ? lr : ((dl && !xp) ? nt : dr);
    dtx = dl ? dr : ((ll && !xp) ? 1'b1 : lr);
    return {1'b1, dtx, ltx};
  endfunction

  function automatic string tag_of(input logic [7:0] lb, input logic [7:0] en,
      input logic pm, input int sel);
    if (sel == 3) return "R3";
    if (!en[7-sel]) return "R9";
    if (sel < 2 && !pm) return "R10";
    if (lb[1] && (lb[7-sel] ^ lb[4-sel])) return "R8";
    if (lb[7-sel] && !lb[4-sel]) return "R6";
    if (lb[4-sel] && !lb[7-sel]) return "R7";
    if (lb[7-sel]) return "R4";
    if (lb[4-sel]) return "R5";
    return "R3";
  endfunction

  task automatic chk_out(input logic [2:0] exp, input string tag);
    total++;
    if ({dig_tx_oe, dig_tx, line_tx} !== exp) begin
      bad++;
      $display("FAIL %s: {oe,dig_tx,line_tx} actual=%b expected=%b", tag,
               {dig_tx_oe, dig_tx, line_tx}, exp);
    end
  endtask

  task automatic wr_cfg(input logic a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    cfg_addr = a;
    @(negedge clk);
    total++;
    if (cfg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: rdata[%0d] actual=%h expected=%h", tag, a, cfg_rdata, exp);
    end
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lpv, env;
    logic [2:0] exp, prev;
    bit prev_ok;
    repeat (3) @(negedge clk);
    chk_out(3'b010, "R1");   // reset values of outputs
    rst = 1'b0;
    rd_chk(1'b0, 8'h00, "R1");
    rd_chk(1'b1, 8'hE0, "R1");

    for (int lp = 0; lp < 128; lp++) begin
      for (int ev = 0; ev < 8; ev++) begin
        lpv = {lp[6:0], ^lp[6:0]};
        env = {ev[2:0], lp[4:0]};
        wr_cfg(1'b0, lpv);
        wr_cfg(1'b1, env);
        rd_chk(1'b0, lpv, "R2");
        rd_chk(1'b1, env, "R2");
        prev_ok = 1'b0;
        prev = '0;
        for (int k = 0; k < 64; k++) begin
          nt_mode  = k[5];
          xpar_ok  = k[4];
          slot_sel = (k[3:2] == 2'd3) ? 3'b000 : (3'b001 << k[3:2]);
          line_rx  = k[1];
          dig_rx   = k[0];
          exp = model(lpv, env, k[5], k[4], int'(k[3:2]), k[1], k[0]);
          #1;
          if (prev_ok) chk_out(prev, "R11");   // no change before the edge
          @(negedge clk);
          chk_out(exp, tag_of(lpv, env, k[4], int'(k[3:2])));
          prev = exp;
          prev_ok = 1'b1;
        end
        slot_sel = '0;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule